// File: doc/BRIEF.md
# GPIO Interrupt Router

The router sits between three GPIO controllers and a platform interrupt controller that has fewer free inputs than there are GPIO interrupt sources. Controller 0 has 14 interrupt lines, controller 1 has 24 and controller 2 (the fabric controller) has 32, which makes 70 sources. They are served by 41 outputs. Thirty-eight outputs are exclusive ("direct") outputs and three are shared outputs that OR together demoted lines.

A 32-bit routing register chooses which source owns each of the 32 contested direct outputs. Every bit pairs one line of controller 0 or 1 with one fixed line of controller 2. The pair member that loses the bit is demoted to the shared output for its own controller. Controller 1 lines 18 to 23 are outside the register and always keep a direct output. The register is written and read over an APB-style bus at byte offset 0x54. Routing is combinational from the sources and the registered control value.

Output numbering: `direct_irq[n]` for n in 0..31 is the winner of control bit n. `direct_irq[32+k]` is controller 1 line 18+k. These 38 outputs map to interrupt-controller inputs 13..50 in index order. `shared_irq[0..2]` map to inputs 51..53.

Top module: `irq_route_top`

## Requirements
- R1: After synchronous reset the routing register reads 0x00000000. With that value every contested direct output carries its controller 0 or controller 1 line.
- R2: A write transfer (psel, penable and pwrite all high at a rising edge) at paddr 0x54 loads pwdata into the register. A read (psel high, pwrite low) at 0x54 returns the register on prdata. The new value steers routing from the cycle after the write edge.
- R3: A read at any other offset returns zero. A write at any other offset, or a transfer with penable low, leaves the register unchanged.
- R4: For bit n in 0..13 with the bit clear, `direct_irq[n]` equals controller 0 line n, and controller 2 line n is demoted.
- R5: For bit n in 0..31 with the bit set, `direct_irq[n]` equals controller 2 line n. The paired controller 0 line n (n<14) or controller 1 line n-14 (n>=14) is demoted.
- R6: For bit n in 14..31 with the bit clear, `direct_irq[n]` equals controller 1 line n-14, and controller 2 line n is demoted.
- R7: `direct_irq[37:32]` always equal controller 1 lines 23..18 (index 32+k carries line 18+k), whatever the register holds. These lines never reach a shared output.
- R8: `shared_irq[0]`, `shared_irq[1]` and `shared_irq[2]` are the OR of the demoted lines of controller 0, controller 1 and controller 2 respectively. Each is 0 when that controller has no asserted demoted line.
- R9: Source levels reach the outputs in the same cycle, with no register stage on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 8 | Bus byte address |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data |
| src0_irq | input | 14 | Controller 0 interrupt lines |
| src1_irq | input | 24 | Controller 1 interrupt lines |
| src2_irq | input | 32 | Controller 2 interrupt lines |
| direct_irq | output | 38 | Exclusive outputs (interrupt inputs 13..50) |
| shared_irq | output | 3 | Shared OR outputs, one per controller (inputs 51..53) |

## Verification
A corrupted routing bit shows on the ports within the same cycle. The affected direct output follows the wrong member of its pair, and the ORed output of one controller picks up or loses that pair's other line. A wrong bit therefore disagrees with the reference as soon as the two paired lines differ, and a read of offset 0x54 exposes it at once. A register that fails to load, or loads from a foreign offset, appears on the first read-back and in the routing of the next source pattern.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int N_SRC0    = 14;
    localparam int N_SRC1    = 24;
    localparam int N_SRC2    = 32;
    localparam int N_SRC1_MX = 18;
    localparam int CTRL_W    = N_SRC0 + N_SRC1_MX;
    localparam int N_FIXED   = N_SRC1 - N_SRC1_MX;
    localparam int N_DIRECT  = CTRL_W + N_FIXED;
    localparam int N_SHARED  = 3;
    localparam int ADDR_W    = 8;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h54;

    typedef struct packed {
        logic [CTRL_W-1:0] direct;
        logic [CTRL_W-1:0] demoted_hard;
        logic [CTRL_W-1:0] demoted_fab;
    } route_t;

    function automatic logic hard_line(input int n,
                                       input logic [N_SRC0-1:0] s0,
                                       input logic [N_SRC1-1:0] s1);
        if (n < N_SRC0) return s0[n];
        return s1[n - N_SRC0];
    endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CTRL_W-1:0] pwdata,
    output logic [CTRL_W-1:0] prdata,
    output logic [CTRL_W-1:0] ctrl
);
    logic hit;
    assign hit = (paddr == CTRL_OFS);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (psel && penable && pwrite && hit)
            ctrl <= pwdata;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite && hit)
            prdata = ctrl;
    end
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
    import irq_route_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [N_SRC0-1:0] src0,
    input  logic [N_SRC1-1:0] src1,
    input  logic [N_SRC2-1:0] src2,
    output route_t            route
);
    for (genvar n = 0; n < CTRL_W; n++) begin : g_pair
        logic hard;
        assign hard = hard_line(n, src0, src1);
        assign route.direct[n]       = ctrl[n] ? src2[n] : hard;
        assign route.demoted_hard[n] = ctrl[n] & hard;
        assign route.demoted_fab[n]  = ~ctrl[n] & src2[n];
    end
endmodule

// File: rtl/irq_route_share.sv
module irq_route_share
    import irq_route_pkg::*;
(
    input  route_t              route,
    output logic [N_SHARED-1:0] shared
);
    assign shared[0] = |route.demoted_hard[N_SRC0-1:0];
    assign shared[1] = |route.demoted_hard[CTRL_W-1:N_SRC0];
    assign shared[2] = |route.demoted_fab;
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [CTRL_W-1:0]   pwdata,
    output logic [CTRL_W-1:0]   prdata,
    input  logic [N_SRC0-1:0]   src0_irq,
    input  logic [N_SRC1-1:0]   src1_irq,
    input  logic [N_SRC2-1:0]   src2_irq,
    output logic [N_DIRECT-1:0] direct_irq,
    output logic [N_SHARED-1:0] shared_irq
);
    logic [CTRL_W-1:0] ctrl_q;
    route_t            route;

    irq_route_regs u_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ctrl(ctrl_q)
    );

    irq_route_xbar u_xbar (
        .ctrl(ctrl_q), .src0(src0_irq), .src1(src1_irq), .src2(src2_irq),
        .route(route)
    );

    irq_route_share u_share (
        .route(route), .shared(shared_irq)
    );

    assign direct_irq = {src1_irq[N_SRC1-1:N_SRC1_MX], route.direct};
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic [ADDR_W-1:0]   paddr,
    input logic [CTRL_W-1:0]   pwdata,
    input logic [CTRL_W-1:0]   prdata,
    input logic [N_SRC0-1:0]   src0_irq,
    input logic [N_SRC1-1:0]   src1_irq,
    input logic [N_SRC2-1:0]   src2_irq,
    input logic [N_DIRECT-1:0] direct_irq,
    input logic [N_SHARED-1:0] shared_irq,
    input logic [CTRL_W-1:0]   ctrl
);
    logic [CTRL_W-1:0] hard_all;
    assign hard_all = {src1_irq[N_SRC1_MX-1:0], src0_irq};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ctrl == '0));

    assert_write_load_R2: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && paddr == CTRL_OFS) |=> (ctrl == $past(pwdata)));

    assert_foreign_write_R3: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && paddr != CTRL_OFS) |=> $stable(ctrl));

    assert_foreign_read_R3: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr != CTRL_OFS) |-> (prdata == '0));

    // R4 and R6: cleared bits hand the direct output to the hard controller
    assert_hard_owner_R4: assert property (@(posedge clk) disable iff (rst)
        ((direct_irq[CTRL_W-1:0] & ~ctrl) == (hard_all & ~ctrl)));

    assert_fab_owner_R5: assert property (@(posedge clk) disable iff (rst)
        ((direct_irq[CTRL_W-1:0] & ctrl) == (src2_irq & ctrl)));

    assert_fixed_lines_R7: assert property (@(posedge clk) disable iff (rst)
        (direct_irq[N_DIRECT-1:CTRL_W] == src1_irq[N_SRC1-1:N_SRC1_MX]));

    assert_shared_fab_R8: assert property (@(posedge clk) disable iff (rst)
        (shared_irq[2] == (|(src2_irq & ~ctrl))));
endmodule

bind irq_route_top irq_route_chk u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .src0_irq(src0_irq), .src1_irq(src1_irq), .src2_irq(src2_irq),
    .direct_irq(direct_irq), .shared_irq(shared_irq), .ctrl(ctrl_q)
);

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;
    import irq_route_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0]   paddr = '0;
    logic [CTRL_W-1:0]   pwdata = '0;
    logic [CTRL_W-1:0]   prdata;
    logic [N_SRC0-1:0]   s0 = '0;
    logic [N_SRC1-1:0]   s1 = '0;
    logic [N_SRC2-1:0]   s2 = '0;
    logic [N_DIRECT-1:0] direct_irq;
    logic [N_SHARED-1:0] shared_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_route_top u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .src0_irq(s0), .src1_irq(s1), .src2_irq(s2),
        .direct_irq(direct_irq), .shared_irq(shared_irq)
    );

    localparam int NV = 6;
    localparam logic [31:0] V_CTRL [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_5555,
                                             32'h0000_3FFF, 32'hFFFF_C000, 32'h8000_2001};
    localparam logic [13:0] V_S0 [NV] = '{14'h3FFF, 14'h3FFF, 14'h1234, 14'h0001, 14'h2AAA, 14'h0000};
    localparam logic [23:0] V_S1 [NV] = '{24'h000000, 24'hFC0000, 24'h3FFFF, 24'h03FFFF, 24'h000001, 24'h020000};
    localparam logic [31:0] V_S2 [NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h5A5A_A5A5, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001};

    // reference built from the requirements: {shared[2:0], direct[37:0]}
    function automatic logic [40:0] model(input logic [31:0] c, input logic [13:0] a,
                                          input logic [23:0] b, input logic [31:0] f);
        logic [37:0] d;
        logic [2:0]  sh;
        logic        h;
        sh = '0;
        d  = '0;
        for (int n = 0; n < 32; n++) begin
            h = (n < 14) ? a[n] : b[n-14];
            if (c[n]) begin
                d[n] = f[n];
                if (n < 14) sh[0] = sh[0] | h; else sh[1] = sh[1] | h;
            end else begin
                d[n] = h;
                sh[2] = sh[2] | f[n];
            end
        end
        for (int k = 0; k < 6; k++) d[32+k] = b[18+k];
        return {sh, d};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic en);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = en;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0;
    endtask

    task automatic route_check(input string req, input logic [31:0] c);
        logic [40:0] e;
        #1;
        e = model(c, s0, s1, s2);
        check(req, {23'd0, shared_irq, direct_irq}, {23'd0, e});
    endtask

    logic [31:0] rd;
    logic [31:0] rc;
    bit          done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset value and hard ownership
        bus_read(8'h54, rd);
        check("R1", {32'd0, rd}, 64'd0);
        s0 = '1; s1 = '1; s2 = '1;
        route_check("R1", 32'd0);

        // table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            bus_write(8'h54, V_CTRL[i], 1'b1);
            bus_read(8'h54, rd);
            check("R2", {32'd0, rd}, {32'd0, V_CTRL[i]});
            s0 = V_S0[i]; s1 = V_S1[i]; s2 = V_S2[i];
            route_check("R4/R5/R6/R8", V_CTRL[i]);
        end

        // R3: foreign offset write ignored, foreign read zero, no-penable write ignored
        bus_write(8'h54, 32'h1357_9BDF, 1'b1);
        bus_write(8'h50, 32'hFFFF_FFFF, 1'b1);
        bus_read(8'h54, rd);
        check("R3", {32'd0, rd}, {32'd0, 32'h1357_9BDF});
        bus_read(8'h58, rd);
        check("R3", {32'd0, rd}, 64'd0);
        bus_write(8'h54, 32'h0, 1'b0);
        bus_read(8'h54, rd);
        check("R3", {32'd0, rd}, {32'd0, 32'h1357_9BDF});

        // R2: change takes effect the cycle after the write edge
        s0 = '0; s1 = '0; s2 = 32'h0000_0001;
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 8'h54; pwdata = 32'h0; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 check("R2", {63'd0, direct_irq[0]}, 64'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1 check("R2", {63'd0, direct_irq[0]}, 64'd0);

        // R7: fixed lines independent of control, never shared
        bus_write(8'h54, 32'hFFFF_FFFF, 1'b1);
        s0 = '0; s1 = 24'hFC0000; s2 = '0;
        route_check("R7", 32'hFFFF_FFFF);
        check("R7", {58'd0, direct_irq[37:32]}, {58'd0, 6'h3F});
        check("R8", {61'd0, shared_irq}, 64'd0);

        // R8: single demoted line of each controller
        bus_write(8'h54, 32'h0000_4001, 1'b1);
        s0 = 14'h0001; s1 = 24'h000001; s2 = 32'h0000_0002;
        route_check("R8", 32'h0000_4001);
        check("R8", {61'd0, shared_irq}, 64'd7);

        // R9: random patterns, same-cycle response to source changes
        for (int i = 0; i < 40; i++) begin
            rc = $urandom;
            bus_write(8'h54, rc, 1'b1);
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                s0 = 14'($urandom); s1 = 24'($urandom); s2 = $urandom;
                route_check("R9", rc);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule